// File: doc/BRIEF.md
# Ordered Memory Group Power State Selector

This block chooses how many of a group of memory devices stay powered up. Each device is either active or powered down, and devices are always switched on in a fixed order: device k may only be active when every device below it is active. The group therefore has only N_DEV+1 legal global states, identified by the number of active devices (0 to N_DEV). The search is done over these few states instead of over every per-device mode combination.

Once per decision period the block scores every global state. The score is the new state's power (the sum of the mode powers of its devices) plus the cost of moving there from the state currently reached. That cost is the largest single-device transition cost, not their sum. A state is eligible only when its predicted response time and its predicted request loss are both within programmable thresholds. The cheapest eligible state is announced as a decision code together with a per-device active mask. The predictions, mode powers and transition costs arrive as inputs from elsewhere. The block then waits for every device to report its own transition as done before it considers the new state reached.

Top module: `gstate_sel`

## Requirements
- R1: While reset is high and after reset, before the first decision: dec_code_o = N_DEV, active_mask_o all ones, state_now_o = N_DEV, busy_o = 0, dec_valid_o = 0. Both thresholds reset to all ones.
- R2: dec_valid_o is a one-cycle pulse. The first pulse follows the PERIOD-th rising edge after reset is released, and later pulses follow every PERIOD cycles, except where R10 skips them.
- R3: dec_code_o is the number of active devices in the chosen state, 0..N_DEV. Bit k of active_mask_o is 1 exactly when k < dec_code_o.
- R4: The power of state j is the sum of pwr_act_i[k] over the devices k < j plus pwr_dn_i[k] over the devices k >= j. Field k of every per-device bus sits at bits [k*W +: W].
- R5: The transition cost from the reached state to state j is the maximum over devices of each device's own cost. That cost is cost_up_i[k] when the device goes from down to active, cost_dn_i[k] when it goes from active to down, and 0 when its mode is unchanged.
- R6: A state j is eligible when pred_resp_i[j] <= the response threshold and pred_loss_i[j] <= the loss threshold (field j at [j*W +: W]). The eligible state with the smallest cost plus power is chosen, and a tie goes to the state with fewer active devices.
- R7: When no state is eligible, state N_DEV (all active) is chosen.
- R8: A write through thr_wr_i updates both thresholds at that rising edge. A decision made at the same edge still uses the old values, and decisions at later edges use the new ones.
- R9: When a decision differs from state_now_o, busy_o rises together with dec_valid_o. It falls at the first edge at which every bit of dev_done_i is 1, and at that edge state_now_o takes the decision code. dev_done_i has no effect while busy_o is low.
- R10: A decision period that ends while busy_o is high issues no decision: dec_valid_o stays 0, and dec_code_o and active_mask_o hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_wr_i | input | 1 | Threshold write strobe |
| thr_resp_i | input | RW | New response time threshold |
| thr_loss_i | input | LW | New request loss threshold |
| pwr_act_i | input | N_DEV*PW | Active-mode power per device |
| pwr_dn_i | input | N_DEV*PW | Powered-down power per device |
| cost_up_i | input | N_DEV*CW | Per-device cost of powering up |
| cost_dn_i | input | N_DEV*CW | Per-device cost of powering down |
| pred_resp_i | input | (N_DEV+1)*RW | Predicted response time per global state |
| pred_loss_i | input | (N_DEV+1)*LW | Predicted request loss per global state |
| dev_done_i | input | N_DEV | Per-device transition-complete flags |
| dec_valid_o | output | 1 | Decision pulse |
| dec_code_o | output | SW | Chosen global state (number of active devices) |
| active_mask_o | output | N_DEV | Per-device active enable |
| busy_o | output | 1 | Global transition in progress |
| state_now_o | output | SW | Global state last reached |

## Verification
The bench builds the block with four devices, 8-bit fields and PERIOD shortened to 8. That keeps every decision interval short, so dozens of randomized decisions, a skipped tick during a stalled transition and a threshold write landing on the very edge of a tick all fit in a few hundred cycles. The 8-bit fields let directed cases force exact ties, a case where a max-based cost and a sum-based cost pick different states, and a case with no eligible state.

// File: rtl/gstate_pkg.sv
package gstate_pkg;
  typedef enum logic {PH_HOLD = 1'b0, PH_MOVE = 1'b1} phase_t;
endpackage

// File: rtl/gstate_tick.sv
module gstate_tick #(
  parameter int PERIOD = 20
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CNW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  logic [CNW-1:0] cnt;

  assign tick_o = (cnt == CNW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (tick_o) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/gstate_eval.sv
module gstate_eval #(
  parameter int N_DEV = 4,
  parameter int PW = 8,
  parameter int CW = 8,
  parameter int RW = 8,
  parameter int LW = 8,
  parameter int SW = 3,
  parameter int TW = 12
) (
  input  logic [SW-1:0]            cur_state_i,
  input  logic [RW-1:0]            thr_resp_i,
  input  logic [LW-1:0]            thr_loss_i,
  input  logic [N_DEV*PW-1:0]      pwr_act_i,
  input  logic [N_DEV*PW-1:0]      pwr_dn_i,
  input  logic [N_DEV*CW-1:0]      cost_up_i,
  input  logic [N_DEV*CW-1:0]      cost_dn_i,
  input  logic [(N_DEV+1)*RW-1:0]  pred_resp_i,
  input  logic [(N_DEV+1)*LW-1:0]  pred_loss_i,
  output logic [(N_DEV+1)*TW-1:0]  total_o,
  output logic [N_DEV:0]           ok_o
);
  for (genvar j = 0; j <= N_DEV; j++) begin : g_state
    logic [TW-1:0] pwr_sum;
    logic [CW-1:0] worst;
    always_comb begin
      pwr_sum = '0;
      worst   = '0;
      for (int k = 0; k < N_DEV; k++) begin
        logic was_on, now_on;
        logic [CW-1:0] step;
        was_on = (k < int'(cur_state_i));
        now_on = (k < j);
        if (now_on) pwr_sum = pwr_sum + TW'(pwr_act_i[k*PW +: PW]);
        else        pwr_sum = pwr_sum + TW'(pwr_dn_i[k*PW +: PW]);
        if (was_on == now_on) step = '0;
        else if (now_on)      step = cost_up_i[k*CW +: CW];
        else                  step = cost_dn_i[k*CW +: CW];
        if (step > worst) worst = step;
      end
    end
    assign total_o[j*TW +: TW] = pwr_sum + TW'(worst);
    assign ok_o[j] = (pred_resp_i[j*RW +: RW] <= thr_resp_i) &&
                     (pred_loss_i[j*LW +: LW] <= thr_loss_i);
  end
endmodule

// File: rtl/gstate_pick.sv
module gstate_pick #(
  parameter int N_DEV = 4,
  parameter int SW = 3,
  parameter int TW = 12
) (
  input  logic [(N_DEV+1)*TW-1:0] total_i,
  input  logic [N_DEV:0]          ok_i,
  output logic [SW-1:0]           pick_o
);
  always_comb begin
    logic          found;
    logic [TW-1:0] best;
    found  = 1'b0;
    best   = '1;
    pick_o = SW'(N_DEV);
    for (int j = 0; j <= N_DEV; j++) begin
      if (ok_i[j] && (!found || total_i[j*TW +: TW] < best)) begin
        found  = 1'b1;
        best   = total_i[j*TW +: TW];
        pick_o = SW'(j);
      end
    end
  end
endmodule

// File: rtl/gstate_sel.sv
module gstate_sel
  import gstate_pkg::*;
#(
  parameter int N_DEV  = 4,
  parameter int PERIOD = 20,
  parameter int PW = 8,
  parameter int CW = 8,
  parameter int RW = 8,
  parameter int LW = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          thr_wr_i,
  input  logic [RW-1:0]                 thr_resp_i,
  input  logic [LW-1:0]                 thr_loss_i,
  input  logic [N_DEV*PW-1:0]           pwr_act_i,
  input  logic [N_DEV*PW-1:0]           pwr_dn_i,
  input  logic [N_DEV*CW-1:0]           cost_up_i,
  input  logic [N_DEV*CW-1:0]           cost_dn_i,
  input  logic [(N_DEV+1)*RW-1:0]       pred_resp_i,
  input  logic [(N_DEV+1)*LW-1:0]       pred_loss_i,
  input  logic [N_DEV-1:0]              dev_done_i,
  output logic                          dec_valid_o,
  output logic [$clog2(N_DEV+1)-1:0]    dec_code_o,
  output logic [N_DEV-1:0]              active_mask_o,
  output logic                          busy_o,
  output logic [$clog2(N_DEV+1)-1:0]    state_now_o
);
  localparam int NS = N_DEV + 1;
  localparam int SW = $clog2(NS);
  localparam int MW = (PW > CW) ? PW : CW;
  localparam int TW = MW + $clog2(NS) + 1;

  logic [RW-1:0]      thr_resp_q;
  logic [LW-1:0]      thr_loss_q;
  logic               tick;
  logic [NS*TW-1:0]   totals;
  logic [NS-1:0]      ok;
  logic [SW-1:0]      pick;
  logic [N_DEV-1:0]   pick_mask;
  phase_t             phase;

  gstate_tick #(.PERIOD(PERIOD)) u_tick (.clk(clk), .rst(rst), .tick_o(tick));

  gstate_eval #(.N_DEV(N_DEV), .PW(PW), .CW(CW), .RW(RW), .LW(LW), .SW(SW), .TW(TW)) u_eval (
    .cur_state_i(state_now_o), .thr_resp_i(thr_resp_q), .thr_loss_i(thr_loss_q),
    .pwr_act_i(pwr_act_i), .pwr_dn_i(pwr_dn_i), .cost_up_i(cost_up_i), .cost_dn_i(cost_dn_i),
    .pred_resp_i(pred_resp_i), .pred_loss_i(pred_loss_i), .total_o(totals), .ok_o(ok));

  gstate_pick #(.N_DEV(N_DEV), .SW(SW), .TW(TW)) u_pick (
    .total_i(totals), .ok_i(ok), .pick_o(pick));

  always_comb begin
    for (int k = 0; k < N_DEV; k++) pick_mask[k] = (k < int'(pick));
  end

  assign busy_o = (phase == PH_MOVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_resp_q    <= '1;
      thr_loss_q    <= '1;
      dec_valid_o   <= 1'b0;
      dec_code_o    <= SW'(N_DEV);
      state_now_o   <= SW'(N_DEV);
      active_mask_o <= '1;
      phase         <= PH_HOLD;
    end else begin
      dec_valid_o <= 1'b0;
      if (thr_wr_i) begin
        thr_resp_q <= thr_resp_i;
        thr_loss_q <= thr_loss_i;
      end
      case (phase)
        PH_HOLD: if (tick) begin
          dec_valid_o   <= 1'b1;
          dec_code_o    <= pick;
          active_mask_o <= pick_mask;
          if (pick != state_now_o) phase <= PH_MOVE;
        end
        PH_MOVE: if (&dev_done_i) begin
          state_now_o <= dec_code_o;
          phase       <= PH_HOLD;
        end
        default: phase <= PH_HOLD;
      endcase
    end
  end
endmodule

// File: rtl/gstate_sel_chk.sv
module gstate_sel_chk #(
  parameter int N_DEV = 4,
  parameter int SW = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             dec_valid_o,
  input logic [SW-1:0]    dec_code_o,
  input logic [N_DEV-1:0] active_mask_o,
  input logic             busy_o,
  input logic [SW-1:0]    state_now_o,
  input logic [N_DEV-1:0] dev_done_i
);
  function automatic logic [N_DEV-1:0] thermo(input int n);
    logic [N_DEV-1:0] r;
    for (int k = 0; k < N_DEV; k++) r[k] = (k < n);
    return r;
  endfunction

  a_r3_code_range: assert property (@(posedge clk) disable iff (rst)
    int'(dec_code_o) <= N_DEV);
  a_r3_mask_matches_code: assert property (@(posedge clk) disable iff (rst)
    active_mask_o == thermo(int'(dec_code_o)));
  a_r3_mask_ordered: assert property (@(posedge clk) disable iff (rst)
    active_mask_o == thermo($countones(active_mask_o)));
  a_r9_wait_for_done: assert property (@(posedge clk) disable iff (rst)
    busy_o && !(&dev_done_i) |=> busy_o && $stable(state_now_o));
  a_r9_settle: assert property (@(posedge clk) disable iff (rst)
    busy_o && (&dev_done_i) |=> !busy_o && state_now_o == $past(dec_code_o));
  a_r10_no_decision_while_busy: assert property (@(posedge clk) disable iff (rst)
    dec_valid_o |-> !$past(busy_o));
  a_r10_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> $stable(dec_code_o) && $stable(active_mask_o));
  a_r1_idle_agrees: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> state_now_o == dec_code_o);
endmodule

bind gstate_sel gstate_sel_chk #(.N_DEV(N_DEV), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .dec_valid_o(dec_valid_o), .dec_code_o(dec_code_o),
  .active_mask_o(active_mask_o), .busy_o(busy_o), .state_now_o(state_now_o),
  .dev_done_i(dev_done_i));

// File: tb/gstate_sel_test.sv
module gstate_sel_test;
  localparam int N = 4;
  localparam int P = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic thr_wr = 1'b0;
  logic [7:0] thr_resp_in = '0, thr_loss_in = '0;
  logic [N*8-1:0] pwr_act, pwr_dn, cost_up, cost_dn;
  logic [(N+1)*8-1:0] pred_resp, pred_loss;
  logic [N-1:0] dev_done = '1;
  logic dec_valid, busy;
  logic [2:0] dec_code, state_now;
  logic [N-1:0] active_mask;

  int pa[N], pd[N], cu[N], cd[N], rs[N+1], ls[N+1];
  int thr_r = 255, thr_l = 255;
  int cur = N;
  int nchk = 0, nbad = 0;
  int cyc = 0, last_dv = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always_comb begin
    for (int k = 0; k < N; k++) begin
      pwr_act[k*8 +: 8] = 8'(pa[k]);
      pwr_dn[k*8 +: 8]  = 8'(pd[k]);
      cost_up[k*8 +: 8] = 8'(cu[k]);
      cost_dn[k*8 +: 8] = 8'(cd[k]);
    end
    for (int j = 0; j <= N; j++) begin
      pred_resp[j*8 +: 8] = 8'(rs[j]);
      pred_loss[j*8 +: 8] = 8'(ls[j]);
    end
  end

  gstate_sel #(.N_DEV(N), .PERIOD(P), .PW(8), .CW(8), .RW(8), .LW(8)) uut (
    .clk(clk), .rst(rst), .thr_wr_i(thr_wr), .thr_resp_i(thr_resp_in), .thr_loss_i(thr_loss_in),
    .pwr_act_i(pwr_act), .pwr_dn_i(pwr_dn), .cost_up_i(cost_up), .cost_dn_i(cost_dn),
    .pred_resp_i(pred_resp), .pred_loss_i(pred_loss), .dev_done_i(dev_done),
    .dec_valid_o(dec_valid), .dec_code_o(dec_code), .active_mask_o(active_mask),
    .busy_o(busy), .state_now_o(state_now));

  function automatic int model_pick(int from);
    int best = N, bestv = 0;
    bit found = 0;
    for (int j = 0; j <= N; j++) begin
      int p = 0, c = 0;
      for (int k = 0; k < N; k++) begin
        bit was_on = (k < from), now_on = (k < j);
        int s = 0;
        p += now_on ? pa[k] : pd[k];
        if (was_on != now_on) s = now_on ? cu[k] : cd[k];
        if (s > c) c = s;
      end
      if (rs[j] <= thr_r && ls[j] <= thr_l && (!found || p + c < bestv)) begin
        found = 1; bestv = p + c; best = j;
      end
    end
    return best;
  endfunction

  function automatic int mask_of(int n);
    return (1 << n) - 1;
  endfunction

  task automatic chk(input bit good, input string req, input int act, input int exp);
    nchk++;
    if (!good) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  endtask

  task automatic wait_dec();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!dec_valid && n < 200);
    chk(dec_valid == 1'b1, "R2 decision pulse seen", int'(dec_valid), 1);
  endtask

  task automatic write_thr(input int r, input int l);
    thr_resp_in = 8'(r); thr_loss_in = 8'(l); thr_wr = 1'b1;
    @(negedge clk);
    thr_wr = 1'b0;
    thr_r = r; thr_l = l;
  endtask

  // checks a decision at its pulse, then lets the transition settle (dev_done high)
  task automatic check_decision(input string req, input int exp);
    chk(int'(dec_code) == exp, req, int'(dec_code), exp);
    chk(int'(active_mask) == mask_of(exp), "R3 mask", int'(active_mask), mask_of(exp));
    chk(busy == (exp != cur), "R9 busy on change", int'(busy), int'(exp != cur));
    @(negedge clk);
    chk(!busy && int'(state_now) == exp, "R9 state reached", int'(state_now), exp);
    chk(!dec_valid, "R2 one-cycle pulse", int'(dec_valid), 0);
    cur = exp;
  endtask

  task automatic set_default();
    for (int k = 0; k < N; k++) begin pa[k] = 10; pd[k] = 1; cu[k] = 0; cd[k] = 0; end
    for (int j = 0; j <= N; j++) begin rs[j] = 0; ls[j] = 0; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    summary();
  end

  initial begin
    int e;
    void'($urandom(32'd1234));
    set_default();
    repeat (4) @(negedge clk);
    // R1: reset values
    chk(int'(dec_code) == N && int'(state_now) == N, "R1 reset state", int'(dec_code), N);
    chk(active_mask == 4'hF && !busy && !dec_valid, "R1 reset mask", int'(active_mask), 15);
    rst = 1'b0;
    last_dv = cyc;
    wait_dec();
    chk(cyc - last_dv == P, "R2 first period", cyc - last_dv, P);
    last_dv = cyc;
    check_decision("R6 default pick", model_pick(cur));
    wait_dec();
    chk(cyc - last_dv == P, "R2 steady period", cyc - last_dv, P);
    check_decision("R6 repeat pick", model_pick(cur));

    // R6 tie: all totals equal -> fewest active
    for (int k = 0; k < N; k++) begin pa[k] = 5; pd[k] = 5; end
    wait_dec();
    check_decision("R6 tie to fewer active", 0);

    // R4 power sum
    pa = '{3, 1, 9, 2}; pd = '{4, 4, 4, 4};
    wait_dec();
    check_decision("R4 power sum", 2);

    // R5 max cost, R8 threshold used
    pa = '{1, 1, 1, 1}; pd = '{1, 1, 1, 1};
    cd = '{2, 3, 0, 0}; cu = '{0, 0, 7, 2};
    rs[2] = 200;
    write_thr(100, 255);
    wait_dec();
    check_decision("R5 max transition cost", 0);

    // R8 write landing on the tick edge uses old values
    set_default();
    rs[0] = 50;
    repeat (P - 2) @(negedge clk);
    write_thr(40, 255);
    chk(dec_valid == 1'b1, "R8 tick aligned", int'(dec_valid), 1);
    thr_r = 100;
    e = model_pick(cur);
    thr_r = 40;
    check_decision("R8 old threshold at same edge", e);
    wait_dec();
    check_decision("R8 new threshold later", 1);

    // R7 nothing eligible
    for (int j = 0; j <= N; j++) ls[j] = 3;
    write_thr(255, 0);
    wait_dec();
    check_decision("R7 fallback all active", N);

    // R9/R10 stalled transition
    set_default();
    write_thr(255, 255);
    dev_done = 4'h7;
    wait_dec();
    chk(int'(dec_code) == 0 && busy, "R9 busy raised", int'(busy), 1);
    for (int i = 0; i < 2 * P; i++) begin
      @(negedge clk);
      chk(!dec_valid && busy, "R10 tick skipped while busy", int'(dec_valid), 0);
      chk(int'(state_now) == N && int'(active_mask) == 0, "R10 outputs hold", int'(state_now), N);
    end
    dev_done = 4'hF;
    @(negedge clk);
    chk(!busy && int'(state_now) == 0, "R9 settle on all done", int'(state_now), 0);
    cur = 0;

    // Random decisions
    for (int it = 0; it < 60; it++) begin
      for (int k = 0; k < N; k++) begin
        pa[k] = $urandom_range(0, 60); pd[k] = $urandom_range(0, 20);
        cu[k] = $urandom_range(0, 80); cd[k] = $urandom_range(0, 80);
      end
      for (int j = 0; j <= N; j++) begin
        rs[j] = $urandom_range(0, 255); ls[j] = $urandom_range(0, 255);
      end
      if ($urandom_range(0, 3) == 0) write_thr($urandom_range(0, 255), $urandom_range(0, 255));
      wait_dec();
      check_decision("R6 random pick", model_pick(cur));
    end
    summary();
  end
endmodule